// File: doc/BRIEF.md
# Parity-and-Half Banked Register File with Byte Strobes

This block stores 128 logical 64-bit registers in four 32-bit-wide storage banks. A register is cut into a low and a high 32-bit half, and the two halves go to different banks. Even-numbered and odd-numbered registers also live in separate banks. Each bank has two read ports and one write port. A read port takes a row address and returns the whole 32-bit bank word one clock later.

The single write port takes a full register number, a 64-bit value and an 8-bit byte-enable mask. The block steers the low four bytes to one bank and the high four bytes to the other bank of the same parity. Every byte of a bank word has its own write strobe. A consumer that writes 8-bit or 16-bit element results just raises the matching strobes, and the other bytes keep their contents without a prior read. Arbitration between requesters and any source routing sit outside the block.

Top module: `banked_regfile`

## Requirements
- R1: Register n (0..127) places its low half (bits 31:0) in bank 2*n[0] and its high half (bits 63:32) in bank 2*n[0]+1, at row n[6:1] of that bank. Bank b therefore holds parity b[1] and half b[0].
- R2: Each bank has two independent read ports. Port p of bank b takes its row on rd_row[(2*b+p)*6 +: 6]. The stored word appears on rd_data[(2*b+p)*32 +: 32] after the next rising clock edge (one cycle of latency).
- R3: When wr_en is high and wr_be[k] is high, byte k of register wr_reg takes wr_data[8k+7:8k]. Byte k means register bits 8k+7:8k, so bytes 0..3 sit in the low-half bank and bytes 4..7 in the high-half bank.
- R4: During a write, every byte whose wr_be bit is low keeps its previous value exactly.
- R5: While wr_en is low, no storage changes, whatever wr_be, wr_reg and wr_data hold.
- R6: A read whose row is being written at the same clock edge returns the contents from before that write.
- R7: Synchronous active-high reset clears every stored byte and every read output to zero.
- R8: A write changes only the two banks whose parity equals wr_reg[0]. The banks of the other parity are untouched.
- R9: Both read ports of one bank may address the same row or different rows in the same cycle, and each returns its own row's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_row | input | 48 | Row address for each bank read port, 6 bits per port, index 2*bank+port |
| rd_data | output | 256 | Registered read word for each bank read port, 32 bits per port, same indexing |
| wr_en | input | 1 | Write request |
| wr_reg | input | 7 | Register number being written |
| wr_data | input | 64 | Write value, byte k in bits 8k+7:8k |
| wr_be | input | 8 | Per-byte write enable |

## Verification
Two functions can meet at the same clock edge: a read port sampling a row, and the write port updating that same row, possibly with only some bytes enabled. The bench provokes this in directed steps, with full and partial masks aimed at the row both read ports are addressing. It also provokes it often in random traffic, with register numbers drawn from a narrow window. The bench model computes each expected read word from its copy of storage before it applies that cycle's write. Any returned word that shows a new byte, or loses an old one, counts as a mismatch.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int REG_COUNT      = 128;
    localparam int REG_W          = 64;
    localparam int BYTE_W         = 8;
    localparam int HALVES         = 2;
    localparam int PARITIES       = 2;
    localparam int RD_PORTS       = 2;

    localparam int HALF_W         = REG_W / HALVES;
    localparam int NUM_BANKS      = HALVES * PARITIES;
    localparam int BANK_ROWS      = REG_COUNT / PARITIES;
    localparam int ROW_W          = $clog2(BANK_ROWS);
    localparam int REG_IDX_W      = $clog2(REG_COUNT);
    localparam int HALF_BYTES     = HALF_W / BYTE_W;
    localparam int REG_BYTES      = REG_W / BYTE_W;
    localparam int RD_TOTAL       = NUM_BANKS * RD_PORTS;

    typedef logic [ROW_W-1:0]      row_t;
    typedef logic [REG_IDX_W-1:0]  reg_idx_t;
    typedef logic [HALF_W-1:0]     half_word_t;
    typedef logic [HALF_BYTES-1:0] half_be_t;

    typedef struct packed {
        row_t       row;
        half_be_t   be;
        half_word_t data;
    } bank_wr_t;

    function automatic logic bank_parity(input int b);
        return logic'((b / HALVES) % PARITIES);
    endfunction

    function automatic int bank_half(input int b);
        return b % HALVES;
    endfunction

    function automatic row_t row_of(input reg_idx_t n);
        return n[REG_IDX_W-1:1];
    endfunction

endpackage

// File: rtl/rf_write_steer.sv
module rf_write_steer
    import regfile_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  reg_idx_t              wr_reg,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [REG_BYTES-1:0]  wr_be,
    output bank_wr_t              bank_wr [NUM_BANKS]
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic PAR = bank_parity(b);
        localparam int   HLF = bank_half(b);

        logic hit;
        assign hit = wr_en && (wr_reg[0] == PAR);

        always_comb begin
            bank_wr[b].row  = row_of(wr_reg);
            bank_wr[b].data = wr_data[HLF*HALF_W +: HALF_W];
            bank_wr[b].be   = hit ? wr_be[HLF*HALF_BYTES +: HALF_BYTES] : '0;
        end

        p_parity_only_r8: assert property (@(posedge clk) disable iff (rst)
            (|bank_wr[b].be) |-> (wr_en && wr_reg[0] == PAR));

        p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            !wr_en |-> (bank_wr[b].be == '0));
    end

endmodule

// File: rtl/rf_bank_store.sv
module rf_bank_store #(
    parameter int WIDTH  = 32,
    parameter int ROWS   = 64,
    parameter int NPORTS = 2,
    parameter int BW     = 8,
    localparam int AW    = $clog2(ROWS),
    localparam int NB    = WIDTH / BW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORTS*AW-1:0]  rd_row,
    output logic [NPORTS*WIDTH-1:0] rd_data,
    input  logic [AW-1:0]         wr_row,
    input  logic [NB-1:0]         wr_be,
    input  logic [WIDTH-1:0]      wr_data
);

    logic [WIDTH-1:0] mem [ROWS];
    logic [NPORTS*WIDTH-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++)
                rd_q[p*WIDTH +: WIDTH] <= mem[rd_row[p*AW +: AW]];
            for (int j = 0; j < NB; j++)
                if (wr_be[j]) mem[wr_row][j*BW +: BW] <= wr_data[j*BW +: BW];
        end
    end

    assign rd_data = rd_q;

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0));

    for (genvar j = 0; j < NB; j++) begin : g_keep
        p_keep_byte_r4: assert property (@(posedge clk) disable iff (rst)
            !wr_be[j] |=> (mem[$past(wr_row)][j*BW +: BW] == $past(mem[wr_row][j*BW +: BW])));
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regfile_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [RD_TOTAL*ROW_W-1:0]    rd_row,
    output logic [RD_TOTAL*HALF_W-1:0]   rd_data,
    input  logic                         wr_en,
    input  logic [REG_IDX_W-1:0]         wr_reg,
    input  logic [REG_W-1:0]             wr_data,
    input  logic [REG_BYTES-1:0]         wr_be
);

    bank_wr_t bank_wr [NUM_BANKS];

    rf_write_steer u_steer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .bank_wr (bank_wr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rf_bank_store #(
            .WIDTH  (HALF_W),
            .ROWS   (BANK_ROWS),
            .NPORTS (RD_PORTS),
            .BW     (BYTE_W)
        ) u_store (
            .clk     (clk),
            .rst     (rst),
            .rd_row  (rd_row[b*RD_PORTS*ROW_W +: RD_PORTS*ROW_W]),
            .rd_data (rd_data[b*RD_PORTS*HALF_W +: RD_PORTS*HALF_W]),
            .wr_row  (bank_wr[b].row),
            .wr_be   (bank_wr[b].be),
            .wr_data (bank_wr[b].data)
        );
    end

endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
    import regfile_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic [RD_TOTAL*ROW_W-1:0]  rd_row = '0;
    logic [RD_TOTAL*HALF_W-1:0] rd_data;
    logic wr_en = 0;
    logic [REG_IDX_W-1:0] wr_reg = '0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_BYTES-1:0] wr_be = '0;

    always #2.5 clk = ~clk;

    banked_regfile dut (.*);

    logic [REG_W-1:0] model [REG_COUNT];
    logic [HALF_W-1:0] exp_w [RD_TOTAL];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    function automatic logic [HALF_W-1:0] model_word(input int b, input int row);
        int n;
        n = row * 2 + (b / 2);
        return model[n][(b % 2)*HALF_W +: HALF_W];
    endfunction

    task automatic check(input string tag, input logic [HALF_W-1:0] act, input logic [HALF_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // port 0 of every bank reads row of register na, port 1 reads row of nb
    function automatic logic [RD_TOTAL*ROW_W-1:0] rows2(input int na, input int nb);
        logic [RD_TOTAL*ROW_W-1:0] r;
        for (int b = 0; b < NUM_BANKS; b++) begin
            r[(b*2)*ROW_W +: ROW_W]   = ROW_W'(na / 2);
            r[(b*2+1)*ROW_W +: ROW_W] = ROW_W'(nb / 2);
        end
        return r;
    endfunction

    task automatic step(input logic we, input int n, input logic [63:0] d,
                        input logic [7:0] be, input logic [RD_TOTAL*ROW_W-1:0] rows,
                        input string tag);
        @(negedge clk);
        wr_en = we; wr_reg = REG_IDX_W'(n); wr_data = d; wr_be = be; rd_row = rows;
        for (int i = 0; i < RD_TOTAL; i++)
            exp_w[i] = model_word(i / 2, int'(rows[i*ROW_W +: ROW_W]));
        if (we)
            for (int k = 0; k < REG_BYTES; k++)
                if (be[k]) model[n][k*8 +: 8] = d[k*8 +: 8];
        @(posedge clk);
        #1;
        for (int i = 0; i < RD_TOTAL; i++)
            check(tag, rd_data[i*HALF_W +: HALF_W], exp_w[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < REG_COUNT; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset output", rd_data[HALF_W-1:0], '0);
        check("R7 reset output", rd_data[RD_TOTAL*HALF_W-1 -: HALF_W], '0);
        @(negedge clk); rst = 0;
        step(0, 0, '0, '0, rows2(0, 127), "R7");
        step(0, 0, '0, '0, rows2(64, 33), "R7");

        // R1 R3: full write, check placement in banks
        step(1, 5, 64'h8877_6655_4433_2211, 8'hFF, rows2(0, 0), "R3");
        step(0, 0, '0, '0, rows2(5, 4), "R1");
        step(1, 6, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, rows2(6, 7), "R8");
        step(0, 0, '0, '0, rows2(6, 7), "R8");
        // R4 partial bytes
        step(1, 5, 64'hFFFF_FFFF_FFFF_FFAA, 8'h01, rows2(5, 6), "R4");
        step(1, 5, 64'h0000_BB00_CC00_0000, 8'h24, rows2(5, 6), "R4");
        step(0, 0, '0, '0, rows2(5, 6), "R4");
        // R5 disabled write with full mask
        step(0, 5, 64'h1234_5678_9ABC_DEF0, 8'hFF, rows2(5, 5), "R5");
        step(0, 0, '0, '0, rows2(5, 5), "R5");
        // R6 same-row read while writing, full and partial
        step(1, 5, 64'h0101_0101_0101_0101, 8'hFF, rows2(5, 5), "R6");
        step(1, 5, 64'hF0F0_F0F0_F0F0_F0F0, 8'h3C, rows2(5, 4), "R6");
        step(0, 0, '0, '0, rows2(5, 4), "R6");
        // R9 both ports same and different rows
        step(1, 127, 64'hA5A5_5A5A_1234_4321, 8'hFF, rows2(2, 3), "R9");
        step(0, 0, '0, '0, rows2(127, 127), "R9");
        step(0, 0, '0, '0, rows2(127, 5), "R9");

        // random traffic with a narrow register window to force collisions
        for (int t = 0; t < 3000; t++) begin
            int n;
            logic [RD_TOTAL*ROW_W-1:0] rr;
            n = (t % 2 == 0) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 127));
            for (int i = 0; i < RD_TOTAL; i++)
                rr[i*ROW_W +: ROW_W] = (t % 3 == 0) ? ROW_W'(n / 2) : ROW_W'($urandom_range(0, 63));
            step(logic'($urandom_range(0, 3) != 0), n, {$urandom, $urandom},
                 8'($urandom), rr, "R2");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule